// File: doc/BRIEF.md
# Control-Slot Flow and Select Unit

This block is the single control slot of a wide-issue core. It holds the program counter and takes one decoded control operation per cycle, along with the scratch operand values that the operation read. It decides the address of the next bundle. The choices are a plain step, an absolute, conditional, PC-relative or register-indirect redirect, a pause, or a frozen halt.

The same slot also performs conditional moves. A scalar select, a lane-wise select over all vector lanes, an add-immediate that needs no arithmetic slot, and a core-number read each produce a scratch write request. That request appears on the write port one cycle after issue, which matches the rule that results land at the end of the issuing cycle.

The external reset is asserted asynchronously and released through a two-stage synchronizer. Internal state therefore leaves reset on the second rising edge after `rst_n` rises.

Top module: `flow_unit`

## Requirements
- R1: While reset is active, and until the second clock edge after `rst_n` rises, `pc` is 0, `halted` and `paused` are 0 and `wr_en` is all zeros.
- R2: In a running cycle with no operation, or with an operation that does not redirect, `pc` advances by one, modulo 2^PC_W. This covers codes 0 (no-op), 5, 6, 7, 8 and a pause that is not stopping.
- R3: An absolute jump (code 1) loads the low PC_W bits of `op_imm` into `pc`.
- R4: A conditional jump (code 2) loads the low bits of `op_imm` when `src_c` is nonzero. Otherwise it steps by one.
- R5: A relative conditional jump (code 3) sets `pc` to the address of the issuing bundle plus the two's-complement `op_imm`, modulo 2^PC_W, when `src_c` is nonzero. Otherwise it steps by one.
- R6: An indirect jump (code 4) loads the low PC_W bits of `src_a` into `pc`.
- R7: A scalar select (code 5) raises only `wr_en[0]` in the next cycle, with `wr_addr` = `op_dst` and lane 0 data = `src_a` if `src_c` is nonzero, else `src_b`. A non-writing operation leaves `wr_en` all zeros in the next cycle.
- R8: A vector select (code 6) raises every `wr_en` bit in the next cycle. Lane i (address `op_dst`+i, data bits [32i+31:32i]) carries the lane-i word of `vsrc_a` when the lane-i word of `vsrc_c` is nonzero, else the lane-i word of `vsrc_b`.
- R9: An add-immediate (code 7) writes `src_a` + `op_imm` modulo 2^32 to lane 0 at `op_dst`.
- R10: A core-number read (code 8) writes the CORE_NUM parameter to lane 0 at `op_dst`.
- R11: A halt (code 10) keeps `pc` at the halt bundle's address and sets `halted`. From then on, until reset, `pc` stays frozen, `wr_en` stays zero and all inputs are ignored.
- R12: With `pause_en` high, a pause (code 9) steps `pc` once and sets `paused`. While paused, `pc` holds and operations are ignored, until a cycle with `resume` high clears `paused`. With `pause_en` low, a pause behaves as a no-op. `resume` has no effect while the unit is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A control operation occupies the slot this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| op_dst | input | ADDR_W | Scratch destination (base for vector select) |
| op_imm | input | XLEN | Immediate: jump target, relative offset or addend |
| src_c | input | XLEN | Scalar condition word |
| src_a | input | XLEN | Scalar operand A / indirect target word |
| src_b | input | XLEN | Scalar operand B |
| vsrc_c | input | LANES*XLEN | Per-lane condition words |
| vsrc_a | input | LANES*XLEN | Per-lane operand A |
| vsrc_b | input | LANES*XLEN | Per-lane operand B |
| pause_en | input | 1 | Pause operations actually stop the unit |
| resume | input | 1 | Leave the paused state |
| pc | output | PC_W | Address of the bundle issuing this cycle |
| halted | output | 1 | Unit has halted |
| paused | output | 1 | Unit is paused |
| wr_en | output | LANES | Per-lane scratch write enable |
| wr_addr | output | ADDR_W | Scratch base address of the write |
| wr_data | output | LANES*XLEN | Write data, lane i in bits [32i+31:32i] |

## Verification
The bench exercises the following corner cases, each chosen to expose a specific mistake.

- **Relative jump base.** It takes relative jumps backwards past address zero and forwards. A unit that added the offset to the incremented PC would land one bundle off.
- **Indirect target width.** It uses an indirect word with bits set above the PC width. A unit that did not truncate that word would show the wrong `pc`.
- **Vector select lane mapping.** The lane mask mixes zero and nonzero conditions. Swapped or shifted lanes would show up as wrong data on exactly those lanes.
- **Add-immediate overflow.** It includes a sum that overflows 32 bits, so any mishandled wrap is visible.
- **Pause and halt.** It issues jumps and selects while paused and while halted, and expects no redirect and no write. It sends a `resume` while halted and expects no effect. It also issues a pause with stopping disabled, which must behave as a plain step.

// File: rtl/flow_pkg.sv
package flow_pkg;

  typedef enum logic [3:0] {
    FOP_NOP     = 4'd0,
    FOP_JMP     = 4'd1,
    FOP_JNZ     = 4'd2,
    FOP_JNZ_REL = 4'd3,
    FOP_JIND    = 4'd4,
    FOP_SEL     = 4'd5,
    FOP_VSEL    = 4'd6,
    FOP_ADDI    = 4'd7,
    FOP_CORE    = 4'd8,
    FOP_PAUSE   = 4'd9,
    FOP_HALT    = 4'd10
  } flow_op_e;

endpackage

// File: rtl/flow_runctl.sv
module flow_runctl
  import flow_pkg::*;
(
  input  logic     clk,
  input  logic     rst_ni,
  input  logic     op_valid_i,
  input  flow_op_e op_i,
  input  logic     pause_en_i,
  input  logic     resume_i,
  output logic     run_o,
  output logic     halted_o,
  output logic     paused_o
);

  logic halted_q, halted_d;
  logic paused_q, paused_d;
  logic halt_hit, pause_hit;

  assign run_o = !halted_q && !paused_q;

  always_comb begin
    halt_hit  = run_o && op_valid_i && (op_i == FOP_HALT);
    pause_hit = run_o && op_valid_i && (op_i == FOP_PAUSE) && pause_en_i;
    halted_d  = halted_q | halt_hit;
    if (pause_hit)     paused_d = 1'b1;
    else if (resume_i) paused_d = 1'b0;
    else               paused_d = paused_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q <= 1'b0;
      paused_q <= 1'b0;
    end else begin
      halted_q <= halted_d;
      paused_q <= paused_d;
    end
  end

  assign halted_o = halted_q;
  assign paused_o = paused_q;

  // R11: once halted, only reset leaves that state
  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    halted_q |=> halted_q);

  // R12: halt and pause never coexist
  p_run_state_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    !(halted_q && paused_q));

endmodule

// File: rtl/flow_branch.sv
module flow_branch
  import flow_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            op_valid_i,
  input  flow_op_e        op_i,
  input  logic            cond_nz_i,
  input  logic [PC_W-1:0] imm_i,
  input  logic [PC_W-1:0] word_i,
  output logic [PC_W-1:0] pc_o
);

  logic [PC_W-1:0] pc_q, pc_d, pc_inc, pc_rel;

  always_comb begin
    pc_inc = pc_q + PC_W'(1);
    pc_rel = pc_q + imm_i;
    pc_d   = pc_inc;
    if (op_valid_i) begin
      case (op_i)
        FOP_JMP:     pc_d = imm_i;
        FOP_JNZ:     if (cond_nz_i) pc_d = imm_i;
        FOP_JNZ_REL: if (cond_nz_i) pc_d = pc_rel;
        FOP_JIND:    pc_d = word_i;
        FOP_HALT:    pc_d = pc_q;
        default:     pc_d = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (run_i) pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R2: an empty running slot steps by exactly one bundle
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_i && !op_valid_i) |=> (pc_q - $past(pc_q)) == PC_W'(1));

  // R3: an absolute jump lands on its immediate
  p_jmp_target_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_i && op_valid_i && op_i == FOP_JMP) |=> pc_q == $past(imm_i));

  // R12: a stalled slot never moves the PC
  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    !run_i |=> $stable(pc_q));

endmodule

// File: rtl/flow_select.sv
module flow_select
  import flow_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int LANES    = 8,
  parameter int CORE_NUM = 0
) (
  input  flow_op_e               op_i,
  input  logic [XLEN-1:0]        imm_i,
  input  logic [XLEN-1:0]        c_i,
  input  logic [XLEN-1:0]        a_i,
  input  logic [XLEN-1:0]        b_i,
  input  logic [LANES*XLEN-1:0]  vc_i,
  input  logic [LANES*XLEN-1:0]  va_i,
  input  logic [LANES*XLEN-1:0]  vb_i,
  output logic [LANES-1:0]       mask_o,
  output logic [LANES*XLEN-1:0]  data_o
);

  logic [XLEN-1:0] s_res;
  logic            is_scalar, is_vec;

  always_comb begin
    is_vec    = (op_i == FOP_VSEL);
    is_scalar = 1'b1;
    s_res     = '0;
    case (op_i)
      FOP_SEL:  s_res = (c_i != '0) ? a_i : b_i;
      FOP_ADDI: s_res = a_i + imm_i;
      FOP_CORE: s_res = XLEN'(CORE_NUM);
      default:  is_scalar = 1'b0;
    endcase
    if (is_vec)         mask_o = {LANES{1'b1}};
    else if (is_scalar) mask_o = LANES'(1);
    else                mask_o = '0;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [XLEN-1:0] lane_pick;
    assign lane_pick = (vc_i[g*XLEN +: XLEN] != '0) ? va_i[g*XLEN +: XLEN]
                                                    : vb_i[g*XLEN +: XLEN];
    if (g == 0) begin : g_first
      assign data_o[g*XLEN +: XLEN] = is_vec ? lane_pick : s_res;
    end else begin : g_rest
      assign data_o[g*XLEN +: XLEN] = lane_pick;
    end
  end

endmodule

// File: rtl/flow_unit.sv
module flow_unit
  import flow_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int XLEN     = 32,
  parameter int LANES    = 8,
  parameter int ADDR_W   = 16,
  parameter int CORE_NUM = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic [3:0]             op_code,
  input  logic [ADDR_W-1:0]      op_dst,
  input  logic [XLEN-1:0]        op_imm,
  input  logic [XLEN-1:0]        src_c,
  input  logic [XLEN-1:0]        src_a,
  input  logic [XLEN-1:0]        src_b,
  input  logic [LANES*XLEN-1:0]  vsrc_c,
  input  logic [LANES*XLEN-1:0]  vsrc_a,
  input  logic [LANES*XLEN-1:0]  vsrc_b,
  input  logic                   pause_en,
  input  logic                   resume,
  output logic [PC_W-1:0]        pc,
  output logic                   halted,
  output logic                   paused,
  output logic [LANES-1:0]       wr_en,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [LANES*XLEN-1:0]  wr_data
);

  localparam int VW = LANES * XLEN;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  flow_op_e          op;
  logic              run, commit;
  logic [LANES-1:0]  lane_mask, wen_d, wen_q;
  logic [VW-1:0]     lane_data, wdata_q;
  logic [ADDR_W-1:0] waddr_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign op = flow_op_e'(op_code);

  flow_runctl u_runctl (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .op_valid_i (op_valid),
    .op_i       (op),
    .pause_en_i (pause_en),
    .resume_i   (resume),
    .run_o      (run),
    .halted_o   (halted),
    .paused_o   (paused)
  );

  flow_branch #(.PC_W(PC_W)) u_branch (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .run_i      (run),
    .op_valid_i (op_valid),
    .op_i       (op),
    .cond_nz_i  (src_c != '0),
    .imm_i      (op_imm[PC_W-1:0]),
    .word_i     (src_a[PC_W-1:0]),
    .pc_o       (pc)
  );

  flow_select #(.XLEN(XLEN), .LANES(LANES), .CORE_NUM(CORE_NUM)) u_select (
    .op_i   (op),
    .imm_i  (op_imm),
    .c_i    (src_c),
    .a_i    (src_a),
    .b_i    (src_b),
    .vc_i   (vsrc_c),
    .va_i   (vsrc_a),
    .vb_i   (vsrc_b),
    .mask_o (lane_mask),
    .data_o (lane_data)
  );

  assign commit = run && op_valid;
  assign wen_d  = commit ? lane_mask : '0;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) wen_q <= '0;
    else            wen_q <= wen_d;
  end

  always_ff @(posedge clk) begin
    if (|wen_d) begin
      waddr_q <= op_dst;
      wdata_q <= lane_data;
    end
  end

  assign wr_en   = wen_q;
  assign wr_addr = waddr_q;
  assign wr_data = wdata_q;

  // R7: a write is either lane 0 alone or every lane
  p_wr_shape_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en != '0) |-> (wr_en == LANES'(1) || wr_en == {LANES{1'b1}}));

  // R9: add-immediate result wraps modulo 2^XLEN
  p_addi_sum_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (commit && op == FOP_ADDI) |=> wr_data[XLEN-1:0] == $past(src_a + op_imm));

  // R11: a halted unit neither moves nor writes
  p_halt_freeze_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    halted |=> ($stable(pc) && wr_en == '0));

  // R12: paused without resume stays paused with a fixed PC
  p_pause_hold_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    (paused && !resume) |=> (paused && $stable(pc)));

endmodule

// File: tb/sim_flow_unit.sv
module sim_flow_unit;
  import flow_pkg::*;

  localparam int LN = 8;
  localparam int CN = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic op_valid;
  logic [3:0] op_code;
  logic [15:0] op_dst;
  logic [31:0] op_imm, src_c, src_a, src_b;
  logic [LN*32-1:0] vsrc_c, vsrc_a, vsrc_b;
  logic pause_en, resume;
  logic [15:0] pc;
  logic halted, paused;
  logic [LN-1:0] wr_en;
  logic [15:0] wr_addr;
  logic [LN*32-1:0] wr_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int unsigned m_pc;
  bit m_h, m_p;
  logic [LN-1:0] m_wen;
  logic [15:0] m_waddr;
  logic [31:0] m_wd [LN];
  string m_tag;
  int rst_cnt;
  bit n_rst, n_resume;

  always #10 clk = ~clk;

  flow_unit #(.PC_W(16), .XLEN(32), .LANES(LN), .ADDR_W(16), .CORE_NUM(CN)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_dst(op_dst), .op_imm(op_imm), .src_c(src_c), .src_a(src_a),
    .src_b(src_b), .vsrc_c(vsrc_c), .vsrc_a(vsrc_a), .vsrc_b(vsrc_b),
    .pause_en(pause_en), .resume(resume), .pc(pc), .halted(halted),
    .paused(paused), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(pc == m_pc[15:0], m_tag, "pc", 32'(pc), m_pc);
    chk(halted == m_h, m_tag, "halted", 32'(halted), 32'(m_h));
    chk(paused == m_p, m_tag, "paused", 32'(paused), 32'(m_p));
    chk(wr_en == m_wen, m_tag, "wr_en", 32'(wr_en), 32'(m_wen));
    if (m_wen != '0) begin
      chk(wr_addr == m_waddr, m_tag, "wr_addr", 32'(wr_addr), 32'(m_waddr));
      for (int i = 0; i < LN; i++)
        if (m_wen[i])
          chk(wr_data[i*32 +: 32] == m_wd[i], m_tag, $sformatf("lane%0d", i),
              wr_data[i*32 +: 32], m_wd[i]);
    end
  endtask

  task automatic model_step();
    int unsigned npc;
    if (!rst_n || rst_cnt > 0) begin
      if (!rst_n) rst_cnt = 2; else rst_cnt--;
      m_pc = 0; m_h = 0; m_p = 0; m_wen = '0; m_tag = "R1";
      return;
    end
    m_wen = '0;
    if (!m_h && !m_p) begin
      npc = m_pc + 1; m_tag = "R2";
      if (op_valid) begin
        case (op_code)
          4'd1: begin npc = op_imm; m_tag = "R3"; end
          4'd2: begin if (src_c != 0) npc = op_imm; m_tag = "R4"; end
          4'd3: begin if (src_c != 0) npc = m_pc + op_imm; m_tag = "R5"; end
          4'd4: begin npc = src_a; m_tag = "R6"; end
          4'd5: begin
            m_wen = 8'h01; m_waddr = op_dst; m_tag = "R7";
            m_wd[0] = (src_c != 0) ? src_a : src_b;
          end
          4'd6: begin
            m_wen = 8'hFF; m_waddr = op_dst; m_tag = "R8";
            for (int i = 0; i < LN; i++)
              m_wd[i] = (vsrc_c[i*32 +: 32] != 0) ? vsrc_a[i*32 +: 32] : vsrc_b[i*32 +: 32];
          end
          4'd7: begin m_wen = 8'h01; m_waddr = op_dst; m_wd[0] = src_a + op_imm; m_tag = "R9"; end
          4'd8: begin m_wen = 8'h01; m_waddr = op_dst; m_wd[0] = CN; m_tag = "R10"; end
          4'd9: begin if (pause_en) m_p = 1; m_tag = "R12"; end
          4'd10: begin npc = m_pc; m_h = 1; m_tag = "R11"; end
          default: ;
        endcase
      end
      m_pc = npc & 32'hFFFF;
    end else if (m_h) begin
      m_tag = "R11";
    end else begin
      m_tag = "R12";
      if (resume) m_p = 0;
    end
  endtask

  task automatic send(input logic [3:0] op, input logic v, input logic [15:0] dst,
                      input logic [31:0] imm, input logic [31:0] c,
                      input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    compare();
    rst_n = n_rst; resume = n_resume; n_resume = 0;
    op_valid = v; op_code = op; op_dst = dst; op_imm = imm;
    src_c = c; src_a = a; src_b = b;
    model_step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(4'd0, 1'b0, 16'h0, 0, 0, 0, 0);
  endtask

  initial begin
    rst_n = 0; resume = 0; pause_en = 0; op_valid = 0; op_code = 0;
    op_dst = 0; op_imm = 0; src_c = 0; src_a = 0; src_b = 0;
    vsrc_c = '0; vsrc_a = '0; vsrc_b = '0;
    m_pc = 0; m_h = 0; m_p = 0; m_wen = '0; m_waddr = 0; m_tag = "R1";
    for (int i = 0; i < LN; i++) m_wd[i] = 0;
    rst_cnt = 2; n_rst = 0; n_resume = 0;
    repeat (2) @(negedge clk);
    idle(3);                                   // R1 reset state
    n_rst = 1;
    idle(5);                                   // R1 release then R2 stepping
    send(4'd1, 1, 0, 32'd100, 0, 0, 0);        // R3
    send(4'd0, 1, 0, 0, 0, 0, 0);              // R2 explicit no-op
    send(4'd2, 1, 0, 32'd50, 0, 0, 0);         // R4 not taken
    send(4'd2, 1, 0, 32'd200, 32'd7, 0, 0);    // R4 taken
    send(4'd3, 1, 0, -32'sd5, 1, 0, 0);        // R5 backward
    send(4'd3, 1, 0, 32'd3, 0, 0, 0);          // R5 not taken
    send(4'd3, 1, 0, 32'd10, 32'h80000000, 0, 0); // R5 forward
    send(4'd4, 1, 0, 0, 0, 32'h0001_0123, 0);  // R6 truncation
    send(4'd3, 1, 0, -32'sd300, 1, 0, 0);      // R5 wraps below zero
    send(4'd5, 1, 16'd20, 0, 1, 32'hAAAA_0001, 32'hBBBB_0002); // R7 A
    send(4'd5, 1, 16'd21, 0, 0, 32'hAAAA_0003, 32'hBBBB_0004); // R7 B
    for (int i = 0; i < LN; i++) begin
      vsrc_c[i*32 +: 32] = (i % 3 == 0) ? 32'd0 : 32'(i * 3);
      vsrc_a[i*32 +: 32] = 32'hA000_0000 + 32'(i);
      vsrc_b[i*32 +: 32] = 32'hB000_0000 + 32'(i);
    end
    send(4'd6, 1, 16'd40, 0, 0, 0, 0);         // R8 mixed lanes
    send(4'd0, 1, 0, 0, 0, 0, 0);              // R7 no write after no-op
    send(4'd7, 1, 16'd3, 32'd2, 0, 32'hFFFF_FFFF, 0); // R9 wrap
    send(4'd7, 1, 16'd4, -32'sd3, 0, 32'd10, 0);      // R9 negative
    send(4'd8, 1, 16'd9, 0, 0, 0, 0);          // R10
    pause_en = 0;
    send(4'd9, 1, 0, 0, 0, 0, 0);              // R12 pause ignored
    n_resume = 1;
    send(4'd0, 0, 0, 0, 0, 0, 0);              // R12 resume while running
    pause_en = 1;
    send(4'd9, 1, 0, 0, 0, 0, 0);              // R12 pause taken
    send(4'd1, 1, 0, 32'd7, 0, 0, 0);          // R12 jump ignored
    send(4'd5, 1, 16'd5, 0, 1, 32'h1234, 0);   // R12 select ignored
    n_resume = 1;
    send(4'd0, 0, 0, 0, 0, 0, 0);              // R12 resume
    idle(2);
    send(4'd10, 1, 0, 0, 0, 0, 0);             // R11 halt
    send(4'd1, 1, 0, 32'd9, 0, 0, 0);          // R11 jump ignored
    send(4'd6, 1, 16'd40, 0, 0, 0, 0);         // R11 select ignored
    n_resume = 1;
    send(4'd0, 0, 0, 0, 0, 0, 0);              // R11 resume no effect
    idle(2);
    n_rst = 0;
    idle(3);                                   // R1 reset again
    n_rst = 1;
    idle(3);
    send(4'd1, 1, 0, 32'h0000_FFFF, 0, 0, 0);  // R3 top address
    idle(2);                                   // R2 wrap to zero
    @(negedge clk);
    compare();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule